// File: doc/BRIEF.md
# Four-State External Read Cycle Controller

This block runs one external read at a time on behalf of a processor's sequencer. A one-cycle start request carries the address space (program or data), the access size (byte or word) and the address. The controller walks the read through four fixed states of one clock each, S0 to S3, and then holds the bus in whole wait clocks until the slave answers.

The outputs follow a fixed order. The function code is driven from S0 and the address lines from S1. The address strobe rises at S2 and stays high through S3 and any wait clocks. When the slave acknowledges, the read data is latched and a done pulse releases the sequencer at once. A bus error ends the cycle without data and raises a bus-error exception request. A word read at an odd address never raises the strobe: the cycle stops after S2 and an address-error exception request is raised instead.

Each cycle ends with one clock in which the strobe, function code and address are all released. The block is then idle again.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: While reset is held and after it is released, the block is idle: busy_o, as_o, addr_valid_o, done_o, data_latch_o, berr_exc_o and aerr_exc_o are 0, fc_o is 2'b00 and addr_o is 0.
- R2: A request is accepted only when the block is idle. It captures space_i, word_i and addr_i. In the first clock after acceptance (S0), fc_o shows 2'b10 for program space (space_i=0) or 2'b01 for data space (space_i=1), while addr_valid_o and as_o stay 0.
- R3: In the second clock (S1), addr_valid_o is 1 and addr_o equals the captured address. Outside the states that drive it, addr_o reads 0.
- R4: as_o rises in the third clock (S2) and stays high through S3 and every wait clock.
- R5: If a response is present at the clock edge that ends S3, the cycle finishes with no wait clock and the end pulse appears in the fifth clock after acceptance.
- R6: Each edge from S3 onward that finds neither ack_i nor berr_i adds exactly one whole wait clock. A response that is present only before S3 is ignored.
- R7: An acknowledge latches rdata_i into rdata_o. In the following clock, done_o and data_latch_o are both 1 for exactly one clock, and rdata_o then holds its value until the next acknowledged read.
- R8: A bus error gives one clock of berr_exc_o with done_o at 0, and rdata_o keeps its previous value.
- R9: If ack_i and berr_i are sampled together, the bus error wins. done_o, berr_exc_o and aerr_exc_o are never 1 at the same time.
- R10: A word access (word_i=1) at an odd address never asserts as_o. aerr_exc_o is 1 for one clock in the fourth clock after acceptance, with no done_o. A byte access at an odd address runs normally.
- R11: In the clock that carries the end pulse, as_o, addr_valid_o and fc_o are all released. In the clock after it, busy_o is 0.
- R12: A request that arrives while a cycle is running is ignored, and the captured address, space and size stay stable for the whole cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Start request, sampled only while idle |
| space_i | input | 1 | 0 = program space, 1 = data space |
| word_i | input | 1 | 1 = word access, 0 = byte access |
| addr_i | input | ADDR_W | Read address |
| ack_i | input | 1 | Slave acknowledge |
| berr_i | input | 1 | Slave bus error |
| rdata_i | input | DATA_W | External read data |
| busy_o | output | 1 | A cycle is in progress |
| fc_o | output | 2 | Function code: 10 program, 01 data, 00 released |
| addr_valid_o | output | 1 | Address lines are driven |
| addr_o | output | ADDR_W | Address lines |
| as_o | output | 1 | Address strobe |
| data_latch_o | output | 1 | Read data has just been latched |
| rdata_o | output | DATA_W | Latched read data |
| done_o | output | 1 | Read completed, next step may start |
| berr_exc_o | output | 1 | Bus-error exception request |
| aerr_exc_o | output | 1 | Address-error exception request |

## Verification
The hardest case to reach from the ports is a response that arrives at the wrong moment. An acknowledge that is present during S0 to S2 must be ignored, so the bench holds ack_i high from the request until just before S3 and then checks that the controller still enters a wait clock. It also holds both responses high in the same wait clock to check the priority rule. A second request is driven in the middle of a cycle with a different address, and the bench checks that the address lines do not move.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_S0,
        ST_S1,
        ST_S2,
        ST_S3,
        ST_WAIT,
        ST_ACK,
        ST_BERR,
        ST_AERR
    } bcc_state_e;

    localparam logic [1:0] FC_NONE = 2'b00;
    localparam logic [1:0] FC_DATA = 2'b01;
    localparam logic [1:0] FC_PROG = 2'b10;

endpackage

// File: rtl/bcc_req_capture.sv
module bcc_req_capture #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              space_i,
    input  logic              word_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              space_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              misaligned_o
);

    typedef struct packed {
        logic              space;
        logic              word;
        logic [ADDR_W-1:0] addr;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (load_i) begin
            cap_d.space = space_i;
            cap_d.word  = word_i;
            cap_d.addr  = addr_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign space_o      = cap_q.space;
    assign addr_o       = cap_q.addr;
    assign misaligned_o = cap_q.word & cap_q.addr[0];

endmodule

// File: rtl/bcc_seq.sv
module bcc_seq
    import bcc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic misaligned_i,
    input  logic ack_i,
    input  logic berr_i,
    output logic load_o,
    output logic take_o,
    output logic busy_o,
    output logic fc_en_o,
    output logic addr_en_o,
    output logic as_o,
    output logic done_o,
    output logic berr_exc_o,
    output logic aerr_exc_o
);

    typedef struct packed {
        bcc_state_e st;
        logic       busy;
        logic       fc_en;
        logic       addr_en;
        logic       as;
        logic       done;
        logic       berr;
        logic       aerr;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        load_o = 1'b0;
        take_o = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (req_i) begin
                    load_o  = 1'b1;
                    s_d.st  = ST_S0;
                end
            end
            ST_S0:   s_d.st = ST_S1;
            ST_S1:   s_d.st = ST_S2;
            ST_S2:   s_d.st = misaligned_i ? ST_AERR : ST_S3;
            ST_S3, ST_WAIT: begin
                if (berr_i) begin
                    s_d.st = ST_BERR;
                end else if (ack_i) begin
                    take_o = 1'b1;
                    s_d.st = ST_ACK;
                end else begin
                    s_d.st = ST_WAIT;
                end
            end
            ST_ACK, ST_BERR, ST_AERR: s_d.st = ST_IDLE;
            default: s_d.st = ST_IDLE;
        endcase

        s_d.busy    = (s_d.st != ST_IDLE);
        s_d.fc_en   = (s_d.st inside {ST_S0, ST_S1, ST_S2, ST_S3, ST_WAIT});
        s_d.addr_en = (s_d.st inside {ST_S1, ST_S2, ST_S3, ST_WAIT});
        s_d.as      = (s_d.st inside {ST_S2, ST_S3, ST_WAIT}) && !misaligned_i;
        s_d.done    = (s_d.st == ST_ACK);
        s_d.berr    = (s_d.st == ST_BERR);
        s_d.aerr    = (s_d.st == ST_AERR);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o     = s_q.busy;
    assign fc_en_o    = s_q.fc_en;
    assign addr_en_o  = s_q.addr_en;
    assign as_o       = s_q.as;
    assign done_o     = s_q.done;
    assign berr_exc_o = s_q.berr;
    assign aerr_exc_o = s_q.aerr;

endmodule

// File: rtl/bcc_rdata_latch.sv
module bcc_rdata_latch #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] data_d, data_q;

    always_comb begin
        data_d = data_q;
        if (take_i) begin
            data_d = rdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else begin
            data_q <= data_d;
        end
    end

    assign rdata_o = data_q;

endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
    import bcc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              space_i,
    input  logic              word_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              ack_i,
    input  logic              berr_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              busy_o,
    output logic [1:0]        fc_o,
    output logic              addr_valid_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              as_o,
    output logic              data_latch_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              done_o,
    output logic              berr_exc_o,
    output logic              aerr_exc_o
);

    logic              load;
    logic              take;
    logic              fc_en;
    logic              cap_space;
    logic              cap_mis;
    logic [ADDR_W-1:0] cap_addr;

    bcc_req_capture #(.ADDR_W(ADDR_W)) u_capture (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (load),
        .space_i      (space_i),
        .word_i       (word_i),
        .addr_i       (addr_i),
        .space_o      (cap_space),
        .addr_o       (cap_addr),
        .misaligned_o (cap_mis)
    );

    bcc_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req_i),
        .misaligned_i (cap_mis),
        .ack_i        (ack_i),
        .berr_i       (berr_i),
        .load_o       (load),
        .take_o       (take),
        .busy_o       (busy_o),
        .fc_en_o      (fc_en),
        .addr_en_o    (addr_valid_o),
        .as_o         (as_o),
        .done_o       (done_o),
        .berr_exc_o   (berr_exc_o),
        .aerr_exc_o   (aerr_exc_o)
    );

    bcc_rdata_latch #(.DATA_W(DATA_W)) u_rdata (
        .clk     (clk),
        .rst_n   (rst_n),
        .take_i  (take),
        .rdata_i (rdata_i),
        .rdata_o (rdata_o)
    );

    assign fc_o         = fc_en ? (cap_space ? FC_DATA : FC_PROG) : FC_NONE;
    assign addr_o       = addr_valid_o ? cap_addr : '0;
    assign data_latch_o = done_o;

endmodule

// File: rtl/bus_cycle_ctrl_chk.sv
module bus_cycle_ctrl_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack_i,
    input logic              berr_i,
    input logic              busy_o,
    input logic [1:0]        fc_o,
    input logic              addr_valid_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic              as_o,
    input logic              done_o,
    input logic              berr_exc_o,
    input logic              aerr_exc_o
);

    assert_fc_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (fc_o != 2'b00) && !addr_valid_o && !as_o);

    assert_addr_after_fc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_valid_o) |-> ($past(fc_o) != 2'b00) && (fc_o == $past(fc_o)));

    assert_strobe_after_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(as_o) |-> $past(addr_valid_o) && addr_valid_o);

    assert_done_needs_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(ack_i) && !$past(berr_i));

    assert_single_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, berr_exc_o, aerr_exc_o}));

    assert_no_strobe_on_fault_R10: assert property (@(posedge clk) disable iff (!rst_n)
        aerr_exc_o |-> !as_o && !$past(as_o));

    assert_release_at_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || berr_exc_o || aerr_exc_o) |-> !as_o && !addr_valid_o && (fc_o == 2'b00));

    assert_addr_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid_o && $past(addr_valid_o)) |-> $stable(addr_o));

endmodule

bind bus_cycle_ctrl bus_cycle_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/bus_cycle_ctrl_bench.sv
module bus_cycle_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic        space_i = 1'b0;
    logic        word_i = 1'b0;
    logic [31:0] addr_i = '0;
    logic        ack_i = 1'b0;
    logic        berr_i = 1'b0;
    logic [15:0] rdata_i = '0;
    logic        busy_o;
    logic [1:0]  fc_o;
    logic        addr_valid_o;
    logic [31:0] addr_o;
    logic        as_o;
    logic        data_latch_o;
    logic [15:0] rdata_o;
    logic        done_o;
    logic        berr_exc_o;
    logic        aerr_exc_o;

    int total = 0;
    int bad   = 0;
    logic [15:0] last_data = '0;

    always #2.5 clk = ~clk;

    bus_cycle_ctrl u_bus_cycle_ctrl (.*);

    // {space, word, addr[31:0], waits[3:0], resp[1:0] 0=ack 1=berr 2=both, expect[1:0] 0=done 1=berr 2=aerr, data[15:0]}
    localparam int NV = 8;
    localparam logic [57:0] VEC [NV] = '{
        {1'b0, 1'b1, 32'h0000_1000, 4'd0, 2'd0, 2'd0, 16'h4E71},
        {1'b1, 1'b1, 32'h0000_2002, 4'd3, 2'd0, 2'd0, 16'hBEEF},
        {1'b1, 1'b0, 32'h0000_3001, 4'd1, 2'd0, 2'd0, 16'h00A5},
        {1'b0, 1'b1, 32'h0000_4000, 4'd0, 2'd1, 2'd1, 16'h1111},
        {1'b1, 1'b1, 32'h0000_5004, 4'd2, 2'd2, 2'd1, 16'h2222},
        {1'b1, 1'b1, 32'h0000_6001, 4'd0, 2'd0, 2'd2, 16'h3333},
        {1'b0, 1'b1, 32'hFFFF_FFFE, 4'd5, 2'd0, 2'd0, 16'h1234},
        {1'b0, 1'b0, 32'h8000_0003, 4'd0, 2'd0, 2'd0, 16'h5A5A}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive_resp(input int resp);
        ack_i  = (resp == 0) || (resp == 2);
        berr_i = (resp == 1) || (resp == 2);
    endtask

    task automatic do_read(input logic sp, input logic wd, input logic [31:0] ad,
                           input int waits, input int resp, input int expo,
                           input logic [15:0] dat);
        logic [1:0] fcx;
        fcx = sp ? 2'b01 : 2'b10;
        @(negedge clk);
        req_i = 1'b1; space_i = sp; word_i = wd; addr_i = ad;
        ack_i = 1'b0; berr_i = 1'b0; rdata_i = dat;
        @(negedge clk);                      // S0
        req_i = 1'b0;
        chk("R2 fc in S0", {30'd0, fc_o}, {30'd0, fcx});
        chk("R2 addr not valid in S0", {31'd0, addr_valid_o}, 32'd0);
        chk("R4 no strobe in S0", {31'd0, as_o}, 32'd0);
        @(negedge clk);                      // S1
        chk("R3 addr in S1", addr_o, ad);
        chk("R3 addr valid in S1", {31'd0, addr_valid_o}, 32'd1);
        chk("R4 no strobe in S1", {31'd0, as_o}, 32'd0);
        @(negedge clk);                      // S2
        if (expo == 2) begin
            chk("R10 strobe suppressed in S2", {31'd0, as_o}, 32'd0);
            @(negedge clk);
            chk("R10 address error pulse", {31'd0, aerr_exc_o}, 32'd1);
            chk("R10 no done", {31'd0, done_o}, 32'd0);
            chk("R10 strobe still low", {31'd0, as_o}, 32'd0);
            chk("R11 fc released", {30'd0, fc_o}, 32'd0);
        end else begin
            chk("R4 strobe in S2", {31'd0, as_o}, 32'd1);
            @(negedge clk);                  // S3
            chk("R4 strobe in S3", {31'd0, as_o}, 32'd1);
            if (waits == 0) drive_resp(resp);
            for (int i = 0; i < waits; i++) begin
                @(negedge clk);
                chk("R6 wait clock strobe", {31'd0, as_o}, 32'd1);
                chk("R6 wait clock no end", {29'd0, done_o, berr_exc_o, aerr_exc_o}, 32'd0);
                if (i == waits - 1) drive_resp(resp);
            end
            @(negedge clk);                  // end cycle
            ack_i = 1'b0; berr_i = 1'b0;
            if (expo == 0) begin
                chk("R7 done pulse", {31'd0, done_o}, 32'd1);
                chk("R7 data latch pulse", {31'd0, data_latch_o}, 32'd1);
                chk("R7 data latched", {16'd0, rdata_o}, {16'd0, dat});
                chk("R5 no exception", {30'd0, berr_exc_o, aerr_exc_o}, 32'd0);
                last_data = dat;
            end else begin
                chk("R8 bus error pulse", {31'd0, berr_exc_o}, 32'd1);
                chk("R9 no done on bus error", {31'd0, done_o}, 32'd0);
                chk("R8 data kept", {16'd0, rdata_o}, {16'd0, last_data});
            end
            chk("R11 strobe released", {31'd0, as_o}, 32'd0);
            chk("R11 fc released", {30'd0, fc_o}, 32'd0);
            chk("R11 addr released", {31'd0, addr_valid_o}, 32'd0);
        end
        @(negedge clk);
        chk("R11 idle after end", {31'd0, busy_o}, 32'd0);
        chk("R7 end pulse one clock", {29'd0, done_o, berr_exc_o, aerr_exc_o}, 32'd0);
    endtask

    initial begin
        #(5.0 * 100000);
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", {31'd0, busy_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle outputs", {25'd0, busy_o, as_o, addr_valid_o, done_o,
                                data_latch_o, berr_exc_o, aerr_exc_o}, 32'd0);
        chk("R1 fc idle", {30'd0, fc_o}, 32'd0);
        chk("R1 addr idle", addr_o, 32'd0);

        for (int v = 0; v < NV; v++) begin
            do_read(VEC[v][57], VEC[v][56], VEC[v][55:24], int'(VEC[v][23:20]),
                    int'(VEC[v][19:18]), int'(VEC[v][17:16]), VEC[v][15:0]);
        end

        // R6: acknowledge before S3 is ignored
        @(negedge clk);
        req_i = 1'b1; space_i = 1'b1; word_i = 1'b1; addr_i = 32'h0000_7000;
        rdata_i = 16'hC0DE; ack_i = 1'b1;
        @(negedge clk); req_i = 1'b0;         // S0
        @(negedge clk);                       // S1
        @(negedge clk); ack_i = 1'b0;         // S2
        @(negedge clk);                       // S3
        chk("R6 strobe in S3 after early ack", {31'd0, as_o}, 32'd1);
        @(negedge clk);
        chk("R6 early ack ignored, waiting", {30'd0, busy_o, done_o}, 32'd2);
        ack_i = 1'b1;
        @(negedge clk); ack_i = 1'b0;
        chk("R6 done after late ack", {31'd0, done_o}, 32'd1);
        chk("R7 data after late ack", {16'd0, rdata_o}, 32'h0000_C0DE);
        @(negedge clk);

        // R12: request during a running cycle is ignored
        @(negedge clk);
        req_i = 1'b1; space_i = 1'b0; word_i = 1'b1; addr_i = 32'h0000_8000;
        rdata_i = 16'h7777;
        @(negedge clk);                       // S0
        addr_i = 32'h0000_9999; space_i = 1'b1;
        @(negedge clk);                       // S1
        chk("R12 addr held in S1", addr_o, 32'h0000_8000);
        chk("R12 space held", {30'd0, fc_o}, 32'd2);
        @(negedge clk); req_i = 1'b0;         // S2
        chk("R12 addr held in S2", addr_o, 32'h0000_8000);
        @(negedge clk); ack_i = 1'b1;         // S3
        chk("R12 addr held in S3", addr_o, 32'h0000_8000);
        @(negedge clk); ack_i = 1'b0;
        chk("R5 zero-wait done", {31'd0, done_o}, 32'd1);
        @(negedge clk);
        chk("R12 no second cycle started", {31'd0, busy_o}, 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule